// File: doc/BRIEF.md
# Virtualized Counter Access Checker

This block owns the hypervisor-level counter-enable register and rules on every attempted read of an unprivileged counter CSR. For each access it gives exactly one of three verdicts: the access may proceed, it raises an illegal-instruction exception, or it raises a virtual-instruction exception. The verdict combines the privilege mode, the virtualization bit, the machine- and supervisor-level enable vectors supplied from outside, and the hypervisor enable vector held here.

When the hart runs virtualized and the machine level allows a counter that the hypervisor level does not, the block reports a virtual-instruction trap. This lets the hypervisor emulate the access instead of seeing an illegal-instruction fault. When the timer-compare extension is strapped in, the time-enable bit also controls guest-supervisor access to the virtual timer-compare register. The register is written through a simple CSR write port that accepts writes only from machine or hypervisor-supervisor mode. Its value is always visible on a read-data output.

Top module: `virt_ctr_access_chk`

## Requirements
- R1: After reset the register reads zero. The decision logic therefore treats every hypervisor enable bit as 0.
- R2: A write takes effect only when `wr_en` is 1, `wr_addr` is 0x606 and the mode is M (`priv`=2'b11) or HS (`priv`=2'b01 with `virt`=0). Any other write leaves the register unchanged.
- R3: Bits 0 (cycle), 1 (time), 2 (instret) and bits 3 to 2+NUM_HPM (hpmcounter3 upward) are writable. Every other bit always reads 0.
- R4: With `priv`=2'b11 (M), every counter or timer-compare access that the block covers is allowed.
- R5: Below M, a counter access whose machine enable bit is 0 raises illegal-instruction, whatever the hypervisor bit holds.
- R6: With `virt`=0 the hypervisor bits are ignored. HS (`priv`=2'b01) is allowed when the machine bit is 1. U (`priv`=2'b00) is allowed when the machine and supervisor bits are both 1, and otherwise raises illegal-instruction.
- R7: With `virt`=1, below M, the machine bit 1 and the hypervisor bit 0, a counter access raises virtual-instruction.
- R8: With `virt`=1 and both the machine and hypervisor bits set, VS is allowed. VU is allowed only if the supervisor bit is also 1, and otherwise raises virtual-instruction.
- R9: Address 0xC00+n selects bit n (n = 0..31). When XLEN=32, 0xC80+n selects the same bit. With `acc_valid`=0, or with any other address, all three verdict outputs are 0.
- R10: The timer-compare addresses are 0x24D, and also 0x25D when XLEN=32. Without `sstc_en` they raise illegal-instruction. With `sstc_en`, the verdict depends on the mode:
  - V=0: S and M are allowed and U is illegal.
  - VU: virtual-instruction.
  - VS: illegal-instruction if machine bit 1 is 0, virtual-instruction if hypervisor bit 1 is 0, and allowed otherwise.
- R11: A register write changes `rd_data` and the verdict from the cycle after the write edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CSR write strobe |
| wr_addr | input | 12 | CSR write address |
| wr_data | input | 32 | CSR write data |
| priv | input | 2 | Current mode: 00 U, 01 S, 11 M |
| virt | input | 1 | Virtualization bit |
| mcen | input | 32 | Machine counter-enable vector |
| scen | input | 32 | Supervisor counter-enable vector in force for the access |
| sstc_en | input | 1 | Timer-compare extension present |
| acc_valid | input | 1 | A counter-class CSR read is being checked |
| acc_addr | input | 12 | Address of the access |
| acc_allow | output | 1 | Access may proceed |
| acc_illegal | output | 1 | Raise illegal-instruction |
| acc_virtual | output | 1 | Raise virtual-instruction |
| rd_data | output | 32 | Current register value |

## Verification
The bench targets the split between the two trap types. A design that checked the hypervisor bit before the machine bit would report virtual-instruction where illegal-instruction is due. A design that ignored the supervisor bit in VU would allow reads the guest kernel has blocked. It also writes all ones and reads back to catch bits for unimplemented counters that a design wrongly kept writable, and it checks the upper-half aliases and unmapped addresses, where a decoder error gives a wrong bit or a spurious verdict. The timer-compare checks cover the strap and each mode. The timing check samples just before and just after the write edge, which exposes a write that bypasses the register or lands one cycle late.

// File: rtl/vca_pkg.sv
// Shared types and constants of the virtualized counter access checker.
// Assumes a 12-bit CSR address space and a 32-entry counter window.
package vca_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CTR  = 2'd1,
        TGT_TCMP = 2'd2
    } tgt_e;

    typedef struct packed {
        logic allow;
        logic illegal;
        logic virt;
    } verdict_t;

    localparam logic [11:0] HCEN_ADDR    = 12'h606;
    localparam logic [11:0] CTR_BASE     = 12'hC00;
    localparam logic [11:0] CTR_HI_BASE  = 12'hC80;
    localparam logic [11:0] TCMP_ADDR    = 12'h24D;
    localparam logic [11:0] TCMP_HI_ADDR = 12'h25D;
    localparam int          TM_BIT       = 1;
endpackage

// File: rtl/hcen_store.sv
// Hypervisor counter-enable storage. Each bit is either a flop (implemented
// counter) or a constant zero (no counter behind it).
// Assumes wr_fire is already qualified by address and privilege.
module hcen_store #(
    parameter int WIDTH   = 32,
    parameter int NUM_HPM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    localparam int LIVE_BITS = 3 + NUM_HPM;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i < LIVE_BITS) begin : g_live
            // Hold one enable bit, clear on reset, load on a qualified write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (wr_fire)
                    q[i] <= wr_data[i];
            end
        end else begin : g_dead
            // No counter behind this bit: it stays zero.
            assign q[i] = 1'b0;
        end
    end

    // R3: bits above the implemented counters never read as 1
    a_r3_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (LIVE_BITS >= WIDTH) || ((q >> LIVE_BITS) == '0));
    // R2: without a write the register keeps its value
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(q));
    // R11: after a write the live bits follow the written data
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (q[2:0] == $past(wr_data[2:0])));
endmodule

// File: rtl/hcen_addr_decode.sv
// Classifies an access address as counter, timer compare or not covered,
// and gives the enable bit index a counter address selects.
// Assumes XLEN is 32 or 64; the upper-half aliases exist only for 32.
module hcen_addr_decode
    import vca_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0] addr,
    output tgt_e        tgt,
    output logic [4:0]  idx
);
    localparam bit HAS_HI = (XLEN == 32);

    // Match the address against the counter windows and timer-compare CSRs.
    always_comb begin
        tgt = TGT_NONE;
        idx = addr[4:0];
        if (addr[11:5] == CTR_BASE[11:5])
            tgt = TGT_CTR;
        else if (HAS_HI && addr[11:5] == CTR_HI_BASE[11:5])
            tgt = TGT_CTR;
        else if (addr == TCMP_ADDR || (HAS_HI && addr == TCMP_HI_ADDR)) begin
            tgt = TGT_TCMP;
            idx = 5'(TM_BIT);
        end
    end
endmodule

// File: rtl/hcen_perm.sv
// Permission evaluator. Combines machine, hypervisor and supervisor enable
// bits with mode and V into one verdict. Assumes the enable bits have already
// been selected by the decoder's index. clk/rst_n serve the assertions only.
module hcen_perm
    import vca_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  tgt_e     tgt,
    input  priv_e    mode,
    input  logic     virt,
    input  logic     m_bit,
    input  logic     s_bit,
    input  logic     h_bit,
    input  logic     sstc_en,
    output verdict_t verdict
);
    localparam verdict_t V_NONE = '{allow: 1'b0, illegal: 1'b0, virt: 1'b0};
    localparam verdict_t V_OK   = '{allow: 1'b1, illegal: 1'b0, virt: 1'b0};
    localparam verdict_t V_ILL  = '{allow: 1'b0, illegal: 1'b1, virt: 1'b0};
    localparam verdict_t V_VIRT = '{allow: 1'b0, illegal: 1'b0, virt: 1'b1};

    logic is_m, is_s;
    assign is_m = (mode == PRIV_M);
    assign is_s = (mode == PRIV_S);

    // Apply machine, then hypervisor, then supervisor gating.
    always_comb begin
        verdict = V_NONE;
        if (valid) begin
            unique case (tgt)
                TGT_CTR: begin
                    if (is_m)            verdict = V_OK;
                    else if (!m_bit)     verdict = V_ILL;
                    else if (!virt) begin
                        if (is_s || s_bit) verdict = V_OK;
                        else               verdict = V_ILL;
                    end
                    else if (!h_bit)     verdict = V_VIRT;
                    else if (is_s || s_bit) verdict = V_OK;
                    else                 verdict = V_VIRT;
                end
                TGT_TCMP: begin
                    if (!sstc_en)        verdict = V_ILL;
                    else if (is_m)       verdict = V_OK;
                    else if (!virt)      verdict = is_s ? V_OK : V_ILL;
                    else if (!is_s)      verdict = V_VIRT;
                    else if (!m_bit)     verdict = V_ILL;
                    else if (!h_bit)     verdict = V_VIRT;
                    else                 verdict = V_OK;
                end
                default:                 verdict = V_NONE;
            endcase
        end
    end

    // R9: never more than one verdict at a time
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({verdict.allow, verdict.illegal, verdict.virt}));
    // R4: machine mode is always allowed on a covered target
    a_r4_m_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && is_m && tgt == TGT_CTR) |-> verdict.allow);
    // R5: machine enable clear below M gives illegal-instruction
    a_r5_m_clear_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_m && tgt == TGT_CTR && !m_bit) |-> verdict.illegal);
    // R7: machine set, hypervisor clear, virtualized gives virtual-instruction
    a_r7_h_clear_virtual: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !is_m && virt && tgt == TGT_CTR && m_bit && !h_bit) |-> verdict.virt);
endmodule

// File: rtl/virt_ctr_access_chk.sv
// Top of the virtualized counter access checker. Holds the hypervisor
// counter-enable register, qualifies writes to it, decodes the access address
// and produces an allow / illegal / virtual verdict combinationally from the
// registered state. Assumes priv and virt describe the mode of both ports.
module virt_ctr_access_chk
    import vca_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int NUM_HPM = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [11:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  priv,
    input  logic        virt,
    input  logic [31:0] mcen,
    input  logic [31:0] scen,
    input  logic        sstc_en,
    input  logic        acc_valid,
    input  logic [11:0] acc_addr,
    output logic        acc_allow,
    output logic        acc_illegal,
    output logic        acc_virtual,
    output logic [31:0] rd_data
);
    priv_e    mode;
    logic     wr_fire;
    logic [31:0] hcen_q;
    tgt_e     tgt;
    logic [4:0] idx;
    verdict_t verdict;

    assign mode = priv_e'(priv);

    // Accept writes from M, or from HS (supervisor mode with V clear).
    assign wr_fire = wr_en && (wr_addr == HCEN_ADDR) &&
                     ((mode == PRIV_M) || (mode == PRIV_S && !virt));

    hcen_store #(.WIDTH(32), .NUM_HPM(NUM_HPM)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_data (wr_data),
        .q       (hcen_q)
    );

    hcen_addr_decode #(.XLEN(XLEN)) u_dec (
        .addr (acc_addr),
        .tgt  (tgt),
        .idx  (idx)
    );

    hcen_perm u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (acc_valid),
        .tgt     (tgt),
        .mode    (mode),
        .virt    (virt),
        .m_bit   (mcen[idx]),
        .s_bit   (scen[idx]),
        .h_bit   (hcen_q[idx]),
        .sstc_en (sstc_en),
        .verdict (verdict)
    );

    assign acc_allow   = verdict.allow;
    assign acc_illegal = verdict.illegal;
    assign acc_virtual = verdict.virt;
    assign rd_data     = hcen_q;

    // R9: no verdict without a valid access
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !(acc_allow || acc_illegal || acc_virtual));
    // R2: a write from a guest mode leaves the register unchanged
    a_r2_guest_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && virt && priv != 2'b11) |=> $stable(rd_data));
endmodule

// File: tb/sim_virt_ctr_access_chk.sv
module sim_virt_ctr_access_chk;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  priv;
    logic        virt;
    logic [31:0] mcen, scen;
    logic        sstc_en, acc_valid;
    logic [11:0] acc_addr;
    logic        acc_allow, acc_illegal, acc_virtual;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;

    localparam logic [2:0] OK = 3'b100, ILL = 3'b010, VRT = 3'b001, NON = 3'b000;
    localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;

    always #(CLK_PERIOD/2) clk = ~clk;

    virt_ctr_access_chk u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .priv(priv), .virt(virt), .mcen(mcen), .scen(scen),
        .sstc_en(sstc_en), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_allow(acc_allow), .acc_illegal(acc_illegal),
        .acc_virtual(acc_virtual), .rd_data(rd_data)
    );

    task automatic chk_dec(string req, logic [1:0] p, logic v, logic [11:0] a,
                           logic [2:0] exp);
        logic [2:0] got;
        priv = p; virt = v; acc_addr = a; acc_valid = 1'b1;
        #1;
        got = {acc_allow, acc_illegal, acc_virtual};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s priv=%b v=%b addr=%h got=%b exp=%b", req, p, v, a, got, exp);
        end
    endtask

    task automatic chk_rd(string req, logic [31:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s rd_data got=%h exp=%h", req, rd_data, exp);
        end
    endtask

    task automatic do_write(logic [1:0] p, logic v, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        priv = p; virt = v; wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk_rd("R1", 32'h0);
        mcen = '1; scen = '1;
        chk_dec("R1", S, 1'b1, 12'hC00, VRT);
    endtask

    task automatic t_write_ctrl;
        do_write(M, 1'b0, 12'h606, 32'h5);   chk_rd("R2", 32'h5);
        do_write(S, 1'b1, 12'h606, 32'hFF);  chk_rd("R2", 32'h5);
        do_write(U, 1'b0, 12'h606, 32'hFF);  chk_rd("R2", 32'h5);
        do_write(S, 1'b0, 12'h106, 32'hFF);  chk_rd("R2", 32'h5);
        do_write(S, 1'b0, 12'h606, 32'h3);   chk_rd("R2", 32'h3);
    endtask

    task automatic t_mask;
        do_write(M, 1'b0, 12'h606, 32'hFFFF_FFFF);
        chk_rd("R3", 32'h0000_07FF);
    endtask

    task automatic t_mmode;
        mcen = '0;
        chk_dec("R4", M, 1'b0, 12'hC00, OK);
        chk_dec("R4", M, 1'b0, 12'hC1F, OK);
    endtask

    task automatic t_mzero;
        mcen = '0; scen = '1;   // hcen holds 0x7FF from t_mask
        chk_dec("R5", S, 1'b1, 12'hC01, ILL);
        chk_dec("R5", U, 1'b1, 12'hC01, ILL);
        chk_dec("R5", S, 1'b0, 12'hC01, ILL);
        chk_dec("R5", U, 1'b0, 12'hC01, ILL);
    endtask

    task automatic t_native;
        do_write(M, 1'b0, 12'h606, 32'h0);
        mcen = '1; scen = '0;
        chk_dec("R6", S, 1'b0, 12'hC02, OK);
        chk_dec("R6", U, 1'b0, 12'hC02, ILL);
        scen = '1;
        chk_dec("R6", U, 1'b0, 12'hC02, OK);
    endtask

    task automatic t_virt_h0;
        do_write(M, 1'b0, 12'h606, 32'h5);
        mcen = '1; scen = '1;
        chk_dec("R7", S, 1'b1, 12'hC01, VRT);
        chk_dec("R7", U, 1'b1, 12'hC01, VRT);
        chk_dec("R7", S, 1'b1, 12'hC1F, VRT);
    endtask

    task automatic t_virt_ok;
        mcen = '1; scen = '1;
        chk_dec("R8", S, 1'b1, 12'hC00, OK);
        chk_dec("R8", U, 1'b1, 12'hC02, OK);
        scen = 32'hFFFF_FFFB;
        chk_dec("R8", U, 1'b1, 12'hC02, VRT);
        chk_dec("R8", S, 1'b1, 12'hC02, OK);
        scen = '1;
    endtask

    task automatic t_addr;
        chk_dec("R9", S, 1'b1, 12'hC82, OK);
        chk_dec("R9", S, 1'b1, 12'hC81, VRT);
        chk_dec("R9", S, 1'b1, 12'hC20, NON);
        chk_dec("R9", S, 1'b1, 12'h300, NON);
        priv = S; virt = 1'b1; acc_addr = 12'hC00; acc_valid = 1'b0;
        #1;
        total++;
        if ({acc_allow, acc_illegal, acc_virtual} !== NON) begin
            bad++;
            $display("FAIL R9 idle got=%b exp=%b",
                     {acc_allow, acc_illegal, acc_virtual}, NON);
        end
    endtask

    task automatic t_tcmp;
        sstc_en = 1'b0;
        chk_dec("R10", S, 1'b1, 12'h24D, ILL);
        sstc_en = 1'b1;
        mcen = 32'hFFFF_FFFD;
        chk_dec("R10", S, 1'b1, 12'h24D, ILL);
        mcen = '1;                            // hcen = 0x5, TM clear
        chk_dec("R10", S, 1'b1, 12'h24D, VRT);
        do_write(M, 1'b0, 12'h606, 32'h2);
        chk_dec("R10", S, 1'b1, 12'h24D, OK);
        chk_dec("R10", S, 1'b1, 12'h25D, OK);
        chk_dec("R10", U, 1'b1, 12'h24D, VRT);
        chk_dec("R10", S, 1'b0, 12'h24D, OK);
        chk_dec("R10", U, 1'b0, 12'h24D, ILL);
    endtask

    task automatic t_timing;
        do_write(M, 1'b0, 12'h606, 32'h0);
        mcen = '1; scen = '1;
        chk_dec("R11", S, 1'b1, 12'hC00, VRT);
        @(negedge clk);
        priv = M; virt = 1'b0; wr_addr = 12'h606; wr_data = 32'h1; wr_en = 1'b1;
        #1;
        chk_rd("R11", 32'h0);              // not yet captured
        @(negedge clk);
        wr_en = 1'b0;
        chk_rd("R11", 32'h1);
        chk_dec("R11", S, 1'b1, 12'hC00, OK);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        priv = M; virt = 1'b0; mcen = '0; scen = '0;
        sstc_en = 1'b0; acc_valid = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_write_ctrl();
        t_mask();
        t_mmode();
        t_mzero();
        t_native();
        t_virt_h0();
        t_virt_ok();
        t_addr();
        t_tcmp();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule